// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter with Clock Generation

This block turns pairs of parallel left/right audio samples into a stereo serial stream. It runs from a master clock at 384 times the sample rate. From that clock it makes a bit clock and a word clock, and it also drives the master clock back out beside them, so a downstream converter gets all four lines in step. One sample period holds 32, 48 or 64 bit-clock cycles. These come from dividing the master clock by 12, 8 or 6, so every frame is 384 master cycles long whatever the setting.

Samples arrive MSB-aligned in a 24-bit word. Configuration inputs choose the frame length, the framing (I2S, MSB-first left-justified or MSB-first right-justified) and the sample width (16 or 24 bits). The samples and the configuration are both captured at the edge that starts a frame. A one-cycle request pulse then tells the upstream logic to present the next pair before the frame ends.

Top module: `serial_audio_tx`

## Requirements
- R1: While reset is asserted, bclk_o, wclk_o, sdata_o and req_o are all low.
- R2: mclk_o follows the master clock input at all times.
- R3: Frame code 0 divides the master clock by 12 (32 bit slots per frame), code 1 divides it by 8 (48 slots), and codes 2 and 3 divide it by 6 (64 slots). Within each bit period the bit clock is low for the first half of the master cycles and high for the second half. Every frame starts on a bit clock falling edge.
- R4: After the first frame has started, sdata_o and wclk_o change only on a master edge where the bit clock falls.
- R5: The left half of a frame is slots 0 to F/2-1. Format codes 0 and 3 (I2S) drive the word clock low for the left half and high for the right half. Codes 1 (left-justified) and 2 (right-justified) use the opposite polarity.
- R6: With wide=0 the sample is the 16 bits in[23:8], and in[7:0] are ignored. With wide=1 it is all 24 bits, except that frame code 0 always uses 16 bits.
- R7: In I2S, a channel's MSB sits in slot 1 of its half. Slots after the LSB carry zero. Slot 0 of a frame carries the LSB of the previous frame's right sample if the width equals half the frame length, and zero otherwise.
- R8: In left-justified mode, a channel's MSB sits in slot 0 of its half and the slots after the LSB carry zero.
- R9: In right-justified mode, a channel's LSB sits in the last slot of its half and every earlier slot carries the sample's sign bit (in[23]).
- R10: req_o is high for exactly the first master cycle of every frame. The samples and configuration present at the frame-start edge are the ones used for that whole frame, and input changes at any other time have no effect on it.
- R11: The first frame after reset begins on the first master edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_384fs | input | 1 | Master clock, 384 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sel | input | 2 | Frame length code: 0=32, 1=48, 2/3=64 slots |
| fmt_sel | input | 2 | Framing code: 0/3=I2S, 1=left-justified, 2=right-justified |
| wide_sel | input | 1 | 1 selects 24-bit samples, 0 selects 16-bit |
| left_in | input | MAX_W | Left sample, MSB-aligned |
| right_in | input | MAX_W | Right sample, MSB-aligned |
| mclk_o | output | 1 | Master clock driven out |
| bclk_o | output | 1 | Bit clock |
| wclk_o | output | 1 | Word clock |
| sdata_o | output | 1 | Serial data |
| req_o | output | 1 | One-cycle request for the next sample pair |

## Verification
The hardest case to reach is I2S slot 0. It carries the right-channel LSB of the previous frame, sent at the previous frame's width. That bit reaches the line only when the new width equals half the new frame, and the configuration in force may have just changed. The stimulus changes the configuration at every frame boundary and walks all 32 combinations of frame, format and width codes in order. Every frame therefore follows a frame with a different setting, and each output is predicted for every master cycle. A last pair of frames changes the inputs in the middle of a frame to show that they only take effect at the next boundary.

// File: rtl/sat_pkg.sv
package sat_pkg;

   localparam int unsigned DIV_W  = 4;
   localparam int unsigned SLOT_W = 6;

   localparam logic [1:0] FRM_32    = 2'd0;
   localparam logic [1:0] FRM_48    = 2'd1;
   localparam logic [1:0] FMT_I2S   = 2'd0;
   localparam logic [1:0] FMT_LEFT  = 2'd1;
   localparam logic [1:0] FMT_RIGHT = 2'd2;
   localparam logic [1:0] FMT_I2S_B = 2'd3;

   typedef struct packed {
      logic [1:0] frame;
      logic [1:0] fmt;
      logic       wide;
   } cfg_t;

   // last master-cycle index inside one bit period
   function automatic logic [DIV_W-1:0] div_last_of(input logic [1:0] frame);
      case (frame)
         FRM_32:  div_last_of = DIV_W'(11);
         FRM_48:  div_last_of = DIV_W'(7);
         default: div_last_of = DIV_W'(5);
      endcase
   endfunction

   // master cycles the bit clock spends low (and high)
   function automatic logic [DIV_W-1:0] half_div_of(input logic [1:0] frame);
      case (frame)
         FRM_32:  half_div_of = DIV_W'(6);
         FRM_48:  half_div_of = DIV_W'(4);
         default: half_div_of = DIV_W'(3);
      endcase
   endfunction

   function automatic logic [SLOT_W-1:0] slot_last_of(input logic [1:0] frame);
      case (frame)
         FRM_32:  slot_last_of = SLOT_W'(31);
         FRM_48:  slot_last_of = SLOT_W'(47);
         default: slot_last_of = SLOT_W'(63);
      endcase
   endfunction

   function automatic logic [SLOT_W-1:0] slot_half_of(input logic [1:0] frame);
      case (frame)
         FRM_32:  slot_half_of = SLOT_W'(16);
         FRM_48:  slot_half_of = SLOT_W'(24);
         default: slot_half_of = SLOT_W'(32);
      endcase
   endfunction

   function automatic logic is_i2s(input logic [1:0] fmt);
      is_i2s = (fmt == FMT_I2S) || (fmt == FMT_I2S_B);
   endfunction

endpackage

// File: rtl/sat_timing.sv
module sat_timing
   import sat_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  cfg_t              cfg_i,
   output logic              load_o,
   output cfg_t              cfg_q_o,
   output cfg_t              cfg_n_o,
   output logic [SLOT_W-1:0] slot_n_o,
   output logic              started_o,
   output logic              bclk_o,
   output logic              wclk_o,
   output logic              req_o
);

   logic [DIV_W-1:0]  div_q, div_n;
   logic [SLOT_W-1:0] slot_q, slot_n;
   logic              load_q, load, wrap;
   logic              started_q;
   logic              bclk_n, wclk_n, second_n;
   logic [DIV_W-1:0]  run_q;
   cfg_t              cfg_q, cfg_n;

   always_comb begin
      wrap   = (div_q == div_last_of(cfg_q.frame));
      load   = load_q || (wrap && (slot_q == slot_last_of(cfg_q.frame)));
      cfg_n  = load ? cfg_i : cfg_q;
      if (load) begin
         div_n  = '0;
         slot_n = '0;
      end else if (wrap) begin
         div_n  = '0;
         slot_n = slot_q + 1'b1;
      end else begin
         div_n  = div_q + 1'b1;
         slot_n = slot_q;
      end
      bclk_n   = (div_n >= half_div_of(cfg_n.frame));
      second_n = (slot_n >= slot_half_of(cfg_n.frame));
      wclk_n   = is_i2s(cfg_n.fmt) ? second_n : !second_n;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q     <= '0;
         slot_q    <= '0;
         load_q    <= 1'b1;
         cfg_q     <= '0;
         started_q <= 1'b0;
         bclk_o    <= 1'b0;
         wclk_o    <= 1'b0;
         req_o     <= 1'b0;
         run_q     <= '0;
      end else begin
         div_q     <= div_n;
         slot_q    <= slot_n;
         load_q    <= 1'b0;
         cfg_q     <= cfg_n;
         started_q <= started_q | load;
         bclk_o    <= bclk_n;
         wclk_o    <= wclk_n;
         req_o     <= load;
         run_q     <= (load_q || (bclk_n != bclk_o)) ? DIV_W'(1) : run_q + 1'b1;
      end
   end

   assign load_o    = load;
   assign cfg_q_o   = cfg_q;
   assign cfg_n_o   = cfg_n;
   assign slot_n_o  = slot_n;
   assign started_o = started_q;

   // bit clock low phase lasts exactly half a bit period
   assert_bclk_half_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(started_q) && $rose(bclk_o)) |-> ($past(run_q) == half_div_of(cfg_q.frame)));

   assert_wclk_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(started_q) && (wclk_o != $past(wclk_o))) |-> $fell(bclk_o));

   assert_req_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o |=> !req_o);

endmodule

// File: rtl/sat_sample_reg.sv
module sat_sample_reg #(
   parameter int unsigned MAX_W    = 24,
   parameter int unsigned NARROW_W = 16
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  load_i,
   input  logic                  narrow_q_i,
   input  logic [MAX_W-1:0]      left_i,
   input  logic [MAX_W-1:0]      right_i,
   output logic [1:0][MAX_W-1:0] smp_n_o,
   output logic                  tail_n_o
);

   localparam int unsigned NARROW_LSB = MAX_W - NARROW_W;

   logic [1:0][MAX_W-1:0] smp_in;
   logic [1:0][MAX_W-1:0] smp_q;
   logic                  tail_q, tail_src;

   assign smp_in[0] = left_i;
   assign smp_in[1] = right_i;

   for (genvar c = 0; c < 2; c++) begin : g_ch
      logic [MAX_W-1:0] hold_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     hold_q <= '0;
         else if (load_i) hold_q <= smp_in[c];
      end
      assign smp_q[c]   = hold_q;
      assign smp_n_o[c] = load_i ? smp_in[c] : hold_q;
   end

   // right-channel LSB of the outgoing frame, at the width it was sent with
   assign tail_src = narrow_q_i ? smp_q[1][NARROW_LSB] : smp_q[1][0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     tail_q <= 1'b0;
      else if (load_i) tail_q <= tail_src;
   end

   assign tail_n_o = load_i ? tail_src : tail_q;

endmodule

// File: rtl/sat_serializer.sv
module sat_serializer
   import sat_pkg::*;
#(
   parameter int unsigned MAX_W       = 24,
   parameter int unsigned NARROW_W    = 16,
   parameter bit          RJ_SIGN_EXT = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  cfg_t                  cfg_n_i,
   input  logic [SLOT_W-1:0]     slot_n_i,
   input  logic [1:0][MAX_W-1:0] smp_n_i,
   input  logic                  tail_n_i,
   output logic                  sdata_o
);

   logic [SLOT_W-1:0] half, width, lead, j, s;
   logic              ch, i2s, rj, d, pad;
   logic [MAX_W-1:0]  word, shifted;

   if (RJ_SIGN_EXT) begin : g_sign_pad
      assign pad = word[MAX_W-1];
   end else begin : g_zero_pad
      assign pad = 1'b0;
   end

   always_comb begin
      half    = slot_half_of(cfg_n_i.frame);
      width   = (cfg_n_i.wide && (cfg_n_i.frame != FRM_32)) ? SLOT_W'(MAX_W)
                                                           : SLOT_W'(NARROW_W);
      i2s     = is_i2s(cfg_n_i.fmt);
      rj      = (cfg_n_i.fmt == FMT_RIGHT);
      lead    = half - width;
      j       = i2s ? slot_n_i - 1'b1 : slot_n_i;
      ch      = (j >= half);
      s       = ch ? j - half : j;
      word    = smp_n_i[ch];
      shifted = '0;
      d       = 1'b0;
      if (i2s && (slot_n_i == '0)) begin
         d = (width == half) ? tail_n_i : 1'b0;
      end else if (rj) begin
         if (s < lead) begin
            d = pad;
         end else begin
            shifted = word << (s - lead);
            d       = shifted[MAX_W-1];
         end
      end else if (s < width) begin
         shifted = word << s;
         d       = shifted[MAX_W-1];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sdata_o <= 1'b0;
      else         sdata_o <= d;
   end

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
   import sat_pkg::*;
#(
   parameter int unsigned MAX_W       = 24,
   parameter int unsigned NARROW_W    = 16,
   parameter bit          RJ_SIGN_EXT = 1'b1
) (
   input  logic             clk_384fs,
   input  logic             rst_n,
   input  logic [1:0]       frame_sel,
   input  logic [1:0]       fmt_sel,
   input  logic             wide_sel,
   input  logic [MAX_W-1:0] left_in,
   input  logic [MAX_W-1:0] right_in,
   output logic             mclk_o,
   output logic             bclk_o,
   output logic             wclk_o,
   output logic             sdata_o,
   output logic             req_o
);

   if ((NARROW_W < 1) || (NARROW_W > 16)) begin : g_bad_narrow
      $error("NARROW_W must fit the 16-slot half of the shortest frame");
   end
   if ((MAX_W < NARROW_W) || (MAX_W > 24)) begin : g_bad_max
      $error("MAX_W must lie between NARROW_W and 24");
   end

   cfg_t                  cfg_in, cfg_q, cfg_n;
   logic                  load, started, narrow_q, tail_n;
   logic [SLOT_W-1:0]     slot_n;
   logic [1:0][MAX_W-1:0] smp_n;

   assign cfg_in   = '{frame: frame_sel, fmt: fmt_sel, wide: wide_sel};
   assign narrow_q = !(cfg_q.wide && (cfg_q.frame != FRM_32));
   assign mclk_o   = clk_384fs;

   sat_timing u_timing (
      .clk_i     (clk_384fs),
      .rst_ni    (rst_n),
      .cfg_i     (cfg_in),
      .load_o    (load),
      .cfg_q_o   (cfg_q),
      .cfg_n_o   (cfg_n),
      .slot_n_o  (slot_n),
      .started_o (started),
      .bclk_o    (bclk_o),
      .wclk_o    (wclk_o),
      .req_o     (req_o)
   );

   sat_sample_reg #(
      .MAX_W    (MAX_W),
      .NARROW_W (NARROW_W)
   ) u_samples (
      .clk_i      (clk_384fs),
      .rst_ni     (rst_n),
      .load_i     (load),
      .narrow_q_i (narrow_q),
      .left_i     (left_in),
      .right_i    (right_in),
      .smp_n_o    (smp_n),
      .tail_n_o   (tail_n)
   );

   sat_serializer #(
      .MAX_W       (MAX_W),
      .NARROW_W    (NARROW_W),
      .RJ_SIGN_EXT (RJ_SIGN_EXT)
   ) u_ser (
      .clk_i    (clk_384fs),
      .rst_ni   (rst_n),
      .cfg_n_i  (cfg_n),
      .slot_n_i (slot_n),
      .smp_n_i  (smp_n),
      .tail_n_i (tail_n),
      .sdata_o  (sdata_o)
   );

   assert_sdata_on_fall_R4: assert property (@(posedge clk_384fs) disable iff (!rst_n)
      ($past(started) && (sdata_o != $past(sdata_o))) |-> $fell(bclk_o));

   assert_req_at_frame_start_R10: assert property (@(posedge clk_384fs) disable iff (!rst_n)
      (req_o && $past(started)) |-> $fell(bclk_o));

endmodule

// File: tb/serial_audio_tx_tb.sv
module serial_audio_tx_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  frame_sel, fmt_sel;
   logic        wide_sel;
   logic [23:0] left_in, right_in;
   logic        mclk_o, bclk_o, wclk_o, sdata_o, req_o;

   int checks = 0;
   int errors = 0;
   logic tail = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_audio_tx u_dut (
      .clk_384fs (clk),
      .rst_n     (rst_n),
      .frame_sel (frame_sel),
      .fmt_sel   (fmt_sel),
      .wide_sel  (wide_sel),
      .left_in   (left_in),
      .right_in  (right_in),
      .mclk_o    (mclk_o),
      .bclk_o    (bclk_o),
      .wclk_o    (wclk_o),
      .sdata_o   (sdata_o),
      .req_o     (req_o)
   );

   task automatic check(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   function automatic logic [23:0] pat(input int k, input bit side);
      logic [23:0] t;
      t = 24'(k * 185523 + (side ? 1418661 : 670815));
      return {(k[0] ^ side), t[22:0]};
   endfunction

   // expected {bclk, wclk, sdata} at master position p of a frame
   function automatic logic [2:0] model(input int p, input int fr, input int fm, input int wd,
                                        input logic [23:0] l, input logic [23:0] r,
                                        input logic tl);
      int D, F, H, W, slot, ph, j, s, lead;
      logic b, w, d, second, i2s;
      logic [23:0] v;
      D = (fr == 0) ? 12 : (fr == 1) ? 8 : 6;
      F = 384 / D;
      H = F / 2;
      W = (wd != 0 && fr != 0) ? 24 : 16;
      slot = p / D;
      ph = p % D;
      b = (ph >= D / 2);
      second = (slot >= H);
      i2s = (fm == 0 || fm == 3);
      w = i2s ? second : !second;
      d = 1'b0;
      if (i2s && slot == 0) begin
         d = (W == H) ? tl : 1'b0;
      end else begin
         j = i2s ? slot - 1 : slot;
         v = (j >= H) ? r : l;
         s = (j >= H) ? j - H : j;
         if (fm == 2) begin
            lead = H - W;
            d = (s < lead) ? v[23] : v[23 - (s - lead)];
         end else begin
            d = (s < W) ? v[23 - s] : 1'b0;
         end
      end
      return {b, w, d};
   endfunction

   task automatic drive(input int fr, input int fm, input int wd,
                        input logic [23:0] l, input logic [23:0] r);
      frame_sel = 2'(fr);
      fmt_sel   = 2'(fm);
      wide_sel  = 1'(wd);
      left_in   = l;
      right_in  = r;
   endtask

   // plays one frame; entered just before the negedge of position 0
   task automatic play(input int fr, input int fm, input int wd,
                       input logic [23:0] l, input logic [23:0] r,
                       input int chg_at, input bit first,
                       input int nfr, input int nfm, input int nwd,
                       input logic [23:0] nl, input logic [23:0] nr);
      logic [2:0] e;
      logic pb, pw, pd;
      string dtag;
      int W;
      W = (wd != 0 && fr != 0) ? 24 : 16;
      dtag = (fm == 1) ? "R8/R6" : (fm == 2) ? "R9/R6" : "R7/R6";
      pb = bclk_o; pw = wclk_o; pd = sdata_o;
      for (int p = 0; p < 384; p++) begin
         @(negedge clk);
         e = model(p, fr, fm, wd, l, r, tail);
         check("R3", "bclk", bclk_o, e[2]);
         check("R5", "wclk", wclk_o, e[1]);
         check(dtag, "sdata", sdata_o, e[0]);
         if (p == 0 && first) check("R11", "first frame req", req_o, 1'b1);
         else                 check("R10", "req", req_o, (p == 0));
         // R4: data and word clock move only with a falling bit clock
         if (!first || p > 0) begin
            if ((sdata_o !== pd) || (wclk_o !== pw))
               check("R4", "change edge", pb & ~bclk_o, 1'b1);
         end
         pb = bclk_o; pw = wclk_o; pd = sdata_o;
         if (p == chg_at) drive(nfr, nfm, nwd, nl, nr);
      end
      tail = r[24 - W];
   endtask

   initial begin
      #(CLK_PERIOD * 60000);
      errors++;
      checks++;
      $display("FAIL R10: watchdog expired, actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int cfr, cfm, cwd, nfr, nfm, nwd;
      logic [23:0] cl, cr, nl, nr;
      rst_n = 1'b0;
      cfr = 0; cfm = 0; cwd = 0;
      cl = pat(0, 0); cr = pat(0, 1);
      drive(cfr, cfm, cwd, cl, cr);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R1", "bclk in reset", bclk_o, 1'b0);
         check("R1", "wclk in reset", wclk_o, 1'b0);
         check("R1", "sdata in reset", sdata_o, 1'b0);
         check("R1", "req in reset", req_o, 1'b0);
      end
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         check("R2", "mclk low phase", mclk_o, 1'b0);
         #(CLK_PERIOD/2 + 1);
         check("R2", "mclk high phase", mclk_o, 1'b1);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // sweep all frame/format/width codes, changing setting every frame
      for (int idx = 0; idx < 32; idx++) begin
         nfr = ((idx + 1) % 32) / 8;
         nfm = (((idx + 1) % 32) / 2) % 4;
         nwd = (idx + 1) % 2;
         nl  = pat(idx + 1, 0);
         nr  = pat(idx + 1, 1);
         play(cfr, cfm, cwd, cl, cr, 0, (idx == 0), nfr, nfm, nwd, nl, nr);
         cfr = nfr; cfm = nfm; cwd = nwd; cl = nl; cr = nr;
      end

      // R10: mid-frame input change must not disturb the running frame
      nfr = 1; nfm = 2; nwd = 1; nl = pat(40, 0); nr = pat(40, 1);
      play(cfr, cfm, cwd, cl, cr, 100, 1'b0, nfr, nfm, nwd, nl, nr);
      cfr = nfr; cfm = nfm; cwd = nwd; cl = nl; cr = nr;
      play(cfr, cfm, cwd, cl, cr, 0, 1'b0, 2, 0, 1, pat(41, 0), pat(41, 1));

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule